// File: doc/BRIEF.md
# DDR SDRAM Command Decoder and Bank Tracker

This block sits on the device side of a 16-bit DDR SDRAM with four banks. On every rising clock edge it samples the select, row strobe, column strobe and write enable pins, the bank select, the 12-bit address, the per-byte mask and the clock enable. From these it classifies the command and latches the row or column address that comes with it. It also keeps an idle or active state for each bank.

All outputs are registered. They change on the clock edge that samples the command. The decoded command comes out as single-cycle strobes. Alongside them the block presents the bank index, the latched row and column addresses, the auto-precharge request, a bitmap of active banks and the latched write mask. A read or write that asks for auto-precharge returns its bank to idle after a parameterised burst length. A command that is illegal for the current bank state raises a protocol-error pulse and changes nothing else. A low clock enable freezes all state. The block reports that case as a plain clock suspend, or as power-down entry when every bank is idle. There is no data stream at this block's edge, so every pin is plain control or status, with no handshake.

Top module: `ddr_cmd_decoder`

## Requirements
- R1: When clk_en is high and sel_n is sampled high, nothing is decoded: no strobe, no error, and bank state and latched addresses stay unchanged. The same holds for the encodings with row and column strobe both low, or both high.
- R2: sel_n=0, row_strobe_n=0, col_strobe_n=1, wr_en_n=1 is activate. If the chosen bank is idle, cmd_act pulses, the bank's bit in bank_active is set, row_addr takes all 12 address bits and bank_o takes bank_sel.
- R3: sel_n=0, row_strobe_n=0, col_strobe_n=1, wr_en_n=0 is precharge. cmd_pre pulses, bank_o takes bank_sel and that bank goes idle. Precharging an idle bank is legal.
- R4: sel_n=0, row_strobe_n=1, col_strobe_n=0 is a column access: wr_en_n=1 is read (cmd_rd) and wr_en_n=0 is write (cmd_wr). If the bank is active, col_addr takes address bits 8..0, auto_pre takes address bit 10 and bank_o takes bank_sel.
- R5: Each strobe lasts one cycle, one cycle after the command is sampled. At most one strobe is high in any cycle.
- R6: A legal read or write with auto_pre set returns its bank to idle exactly BURST_LEN unsuspended clock edges after the command edge, unless a precharge or a newer auto-precharge access to that bank comes first.
- R7: An activate to an active bank, or a read or write to an idle bank, pulses proto_err with no strobe. Bank state and latched fields stay unchanged.
- R8: On an edge where clk_en is low, the command is ignored, all strobes are low, and bank_active, the latched fields and the auto-precharge countdowns hold.
- R9: After an edge with clk_en low, pd_entry is high if all banks are idle, otherwise suspend is high. Both are low after an edge with clk_en high. They are never high together.
- R10: A legal write latches byte_mask into wr_mask, where 1 means the lane is blocked. Bit 0 covers data bits 7..0 and bit 1 covers bits 15..8. Other commands leave wr_mask unchanged.
- R11: While rst_n is low, every bank is idle and every output and latched field is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en | input | 1 | Clock enable; low suspends the block |
| sel_n | input | 1 | Device select, active low |
| row_strobe_n | input | 1 | Row strobe, active low |
| col_strobe_n | input | 1 | Column strobe, active low |
| wr_en_n | input | 1 | Write enable, active low |
| bank_sel | input | 2 | Target bank |
| addr_in | input | 12 | Row or column address |
| byte_mask | input | 2 | Per-byte write mask, 1 blocks the lane |
| cmd_act | output | 1 | Activate strobe |
| cmd_pre | output | 1 | Precharge strobe |
| cmd_rd | output | 1 | Read strobe |
| cmd_wr | output | 1 | Write strobe |
| bank_o | output | 2 | Bank of the last legal command |
| row_addr | output | 12 | Latched row address |
| col_addr | output | 9 | Latched column address |
| auto_pre | output | 1 | Latched auto-precharge request |
| bank_active | output | 4 | Active bitmap, one bit per bank |
| wr_mask | output | 2 | Latched write mask |
| suspend | output | 1 | Clock suspended with a bank active |
| pd_entry | output | 1 | Clock suspended with all banks idle |
| proto_err | output | 1 | Illegal command for the bank state |

## Verification
The assertions check, on every cycle, the properties that hold regardless of history. Strobes are mutually exclusive and no strobe comes with an error. An activate leaves its bank active and a precharge leaves it idle. A low clock enable freezes state, selects exactly one of suspend and power-down entry, and gives power-down entry only with no bank active. A deselected cycle produces nothing. Only the bench's scenarios can show the rest: the exact address and mask values latched, the cycle on which an auto-precharge countdown returns a bank to idle, and a countdown stretched by suspended cycles. These are compared against a reference model driven by a mix of random and directed commands.

// File: rtl/ddr_cmd_pkg.sv
package ddr_cmd_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_PRE = 3'd2,
    CMD_RD  = 3'd3,
    CMD_WR  = 3'd4
  } cmd_e;
endpackage

// File: rtl/ddr_cmd_classify.sv
module ddr_cmd_classify
  import ddr_cmd_pkg::*;
(
  input  logic sel_n,
  input  logic row_strobe_n,
  input  logic col_strobe_n,
  input  logic wr_en_n,
  output cmd_e cmd
);
  always_comb begin
    cmd = CMD_NOP;
    if (!sel_n) begin
      unique case ({row_strobe_n, col_strobe_n})
        2'b01:   cmd = wr_en_n ? CMD_ACT : CMD_PRE;
        2'b10:   cmd = wr_en_n ? CMD_RD : CMD_WR;
        default: cmd = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/ddr_bank_fsm.sv
module ddr_bank_fsm #(
  parameter int BURST_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic act_hit,
  input  logic pre_hit,
  input  logic col_hit,
  input  logic col_ap,
  output logic active
);
  localparam int CNT_W = $clog2(BURST_LEN + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(BURST_LEN);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (run) begin
      if (pre_hit) begin
        active <= 1'b0;
        cnt    <= '0;
      end else if (act_hit) begin
        active <= 1'b1;
      end else if (col_hit && col_ap) begin
        cnt <= LOAD;
      end else if (cnt == CNT_W'(1)) begin
        active <= 1'b0;
        cnt    <= '0;
      end else if (cnt != '0) begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/ddr_addr_latch.sv
module ddr_addr_latch #(
  parameter int ROW_W  = 12,
  parameter int COL_W  = 9,
  parameter int AP_BIT = 10,
  parameter int BA_W   = 2,
  parameter int LANES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_row,
  input  logic             ld_col,
  input  logic             ld_bank,
  input  logic             ld_mask,
  input  logic [ROW_W-1:0] addr_in,
  input  logic [BA_W-1:0]  bank_sel,
  input  logic [LANES-1:0] byte_mask,
  output logic [ROW_W-1:0] row_addr,
  output logic [COL_W-1:0] col_addr,
  output logic             auto_pre,
  output logic [BA_W-1:0]  bank_o,
  output logic [LANES-1:0] wr_mask
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_addr <= '0;
      col_addr <= '0;
      auto_pre <= 1'b0;
      bank_o   <= '0;
      wr_mask  <= '0;
    end else begin
      if (ld_row)  row_addr <= addr_in;
      if (ld_col) begin
        col_addr <= addr_in[COL_W-1:0];
        auto_pre <= addr_in[AP_BIT];
      end
      if (ld_bank) bank_o  <= bank_sel;
      if (ld_mask) wr_mask <= byte_mask;
    end
  end
endmodule

// File: rtl/ddr_cmd_decoder.sv
module ddr_cmd_decoder
  import ddr_cmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 9,
  parameter int AP_BIT    = 10,
  parameter int LANES     = 2,
  parameter int BURST_LEN = 4,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clk_en,
  input  logic                 sel_n,
  input  logic                 row_strobe_n,
  input  logic                 col_strobe_n,
  input  logic                 wr_en_n,
  input  logic [BA_W-1:0]      bank_sel,
  input  logic [ROW_W-1:0]     addr_in,
  input  logic [LANES-1:0]     byte_mask,
  output logic                 cmd_act,
  output logic                 cmd_pre,
  output logic                 cmd_rd,
  output logic                 cmd_wr,
  output logic [BA_W-1:0]      bank_o,
  output logic [ROW_W-1:0]     row_addr,
  output logic [COL_W-1:0]     col_addr,
  output logic                 auto_pre,
  output logic [NUM_BANKS-1:0] bank_active,
  output logic [LANES-1:0]     wr_mask,
  output logic                 suspend,
  output logic                 pd_entry,
  output logic                 proto_err
);
  cmd_e cmd;
  logic tgt_active, all_idle;
  logic ok_act, ok_pre, ok_rd, ok_wr, bad_cmd;

  ddr_cmd_classify u_cls (
    .sel_n        (sel_n),
    .row_strobe_n (row_strobe_n),
    .col_strobe_n (col_strobe_n),
    .wr_en_n      (wr_en_n),
    .cmd          (cmd)
  );

  always_comb begin
    tgt_active = bank_active[bank_sel];
    all_idle   = ~|bank_active;
    ok_act     = clk_en && (cmd == CMD_ACT) && !tgt_active;
    ok_pre     = clk_en && (cmd == CMD_PRE);
    ok_rd      = clk_en && (cmd == CMD_RD) && tgt_active;
    ok_wr      = clk_en && (cmd == CMD_WR) && tgt_active;
    bad_cmd    = clk_en && (((cmd == CMD_ACT) && tgt_active) ||
                 (((cmd == CMD_RD) || (cmd == CMD_WR)) && !tgt_active));
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (bank_sel == BA_W'(b));
    ddr_bank_fsm #(.BURST_LEN(BURST_LEN)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (clk_en),
      .act_hit (ok_act && hit),
      .pre_hit (ok_pre && hit),
      .col_hit ((ok_rd || ok_wr) && hit),
      .col_ap  (addr_in[AP_BIT]),
      .active  (bank_active[b])
    );
  end

  ddr_addr_latch #(
    .ROW_W(ROW_W), .COL_W(COL_W), .AP_BIT(AP_BIT), .BA_W(BA_W), .LANES(LANES)
  ) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_row    (ok_act),
    .ld_col    (ok_rd || ok_wr),
    .ld_bank   (ok_act || ok_pre || ok_rd || ok_wr),
    .ld_mask   (ok_wr),
    .addr_in   (addr_in),
    .bank_sel  (bank_sel),
    .byte_mask (byte_mask),
    .row_addr  (row_addr),
    .col_addr  (col_addr),
    .auto_pre  (auto_pre),
    .bank_o    (bank_o),
    .wr_mask   (wr_mask)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_act   <= 1'b0;
      cmd_pre   <= 1'b0;
      cmd_rd    <= 1'b0;
      cmd_wr    <= 1'b0;
      proto_err <= 1'b0;
      suspend   <= 1'b0;
      pd_entry  <= 1'b0;
    end else begin
      cmd_act   <= ok_act;
      cmd_pre   <= ok_pre;
      cmd_rd    <= ok_rd;
      cmd_wr    <= ok_wr;
      proto_err <= bad_cmd;
      suspend   <= !clk_en && !all_idle;
      pd_entry  <= !clk_en && all_idle;
    end
  end
endmodule

// File: rtl/ddr_cmd_checker.sv
module ddr_cmd_checker #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 9,
  parameter int BA_W      = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 clk_en,
  input logic                 sel_n,
  input logic                 cmd_act,
  input logic                 cmd_pre,
  input logic                 cmd_rd,
  input logic                 cmd_wr,
  input logic [BA_W-1:0]      bank_o,
  input logic [ROW_W-1:0]     row_addr,
  input logic [COL_W-1:0]     col_addr,
  input logic [NUM_BANKS-1:0] bank_active,
  input logic                 suspend,
  input logic                 pd_entry,
  input logic                 proto_err
);
  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_act, cmd_pre, cmd_rd, cmd_wr}));

  assert_deselect_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && sel_n) |=> !(cmd_act || cmd_pre || cmd_rd || cmd_wr || proto_err));

  assert_act_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_act |-> bank_active[bank_o]);

  assert_pre_closes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pre |-> !bank_active[bank_o]);

  assert_err_no_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> !(cmd_act || cmd_pre || cmd_rd || cmd_wr));

  assert_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> ($stable(bank_active) && $stable(row_addr) &&
                 $stable(col_addr) && $stable(bank_o)));

  assert_susp_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> (suspend || pd_entry));

  assert_susp_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({suspend, pd_entry}));

  assert_pd_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pd_entry |-> (bank_active == '0));
endmodule

bind ddr_cmd_decoder ddr_cmd_checker #(
  .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .COL_W(COL_W), .BA_W(BA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sel_n(sel_n),
  .cmd_act(cmd_act), .cmd_pre(cmd_pre), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
  .bank_o(bank_o), .row_addr(row_addr), .col_addr(col_addr),
  .bank_active(bank_active), .suspend(suspend), .pd_entry(pd_entry),
  .proto_err(proto_err)
);

// File: tb/tb_ddr_cmd_decoder.sv
module tb_ddr_cmd_decoder;
  localparam int BL = 4;

  logic clk = 0;
  logic rst_n, clk_en, sel_n, ras, cas, we;
  logic [1:0] bank_sel, byte_mask;
  logic [11:0] addr_in;
  logic cmd_act, cmd_pre, cmd_rd, cmd_wr, auto_pre, suspend, pd_entry, proto_err;
  logic [1:0] bank_o, wr_mask;
  logic [11:0] row_addr;
  logic [8:0] col_addr;
  logic [3:0] bank_active;

  int n_chk = 0, n_fail = 0;

  // reference model state
  logic [3:0] m_active;
  int m_cnt [4];
  logic [11:0] m_row; logic [8:0] m_col; logic m_ap; logic [1:0] m_bank, m_mask;
  logic m_act, m_pre, m_rd, m_wr, m_err, m_susp, m_pd;

  always #10 clk = ~clk;

  ddr_cmd_decoder #(.BURST_LEN(BL)) dut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sel_n(sel_n),
    .row_strobe_n(ras), .col_strobe_n(cas), .wr_en_n(we),
    .bank_sel(bank_sel), .addr_in(addr_in), .byte_mask(byte_mask),
    .cmd_act(cmd_act), .cmd_pre(cmd_pre), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
    .bank_o(bank_o), .row_addr(row_addr), .col_addr(col_addr),
    .auto_pre(auto_pre), .bank_active(bank_active), .wr_mask(wr_mask),
    .suspend(suspend), .pd_entry(pd_entry), .proto_err(proto_err)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_active = '0; m_row = '0; m_col = '0; m_ap = 0; m_bank = '0; m_mask = '0;
    {m_act, m_pre, m_rd, m_wr, m_err, m_susp, m_pd} = '0;
    for (int b = 0; b < 4; b++) m_cnt[b] = 0;
  endtask

  task automatic model_step();
    logic is_act, is_pre, is_rd, is_wr, tgt, ok_act, ok_rd, ok_wr;
    if (!rst_n) begin model_reset(); return; end
    {m_act, m_pre, m_rd, m_wr, m_err} = '0;
    if (!clk_en) begin
      m_pd = (m_active == 0); m_susp = !m_pd; return;
    end
    m_pd = 0; m_susp = 0;
    is_act = !sel_n && !ras && cas && we;
    is_pre = !sel_n && !ras && cas && !we;
    is_rd  = !sel_n && ras && !cas && we;
    is_wr  = !sel_n && ras && !cas && !we;
    tgt = m_active[bank_sel];
    ok_act = is_act && !tgt; ok_rd = is_rd && tgt; ok_wr = is_wr && tgt;
    m_err = (is_act && tgt) || ((is_rd || is_wr) && !tgt);
    for (int b = 0; b < 4; b++) begin
      if (is_pre && bank_sel == b) begin m_active[b] = 0; m_cnt[b] = 0; end
      else if (ok_act && bank_sel == b) m_active[b] = 1;
      else if ((ok_rd || ok_wr) && bank_sel == b && addr_in[10]) m_cnt[b] = BL;
      else if (m_cnt[b] == 1) begin m_active[b] = 0; m_cnt[b] = 0; end
      else if (m_cnt[b] > 0) m_cnt[b]--;
    end
    m_act = ok_act; m_pre = is_pre; m_rd = ok_rd; m_wr = ok_wr;
    if (ok_act) m_row = addr_in;
    if (ok_rd || ok_wr) begin m_col = addr_in[8:0]; m_ap = addr_in[10]; end
    if (ok_act || is_pre || ok_rd || ok_wr) m_bank = bank_sel;
    if (ok_wr) m_mask = byte_mask;
  endtask

  task automatic compare();
    chk("R2", "cmd_act", cmd_act, m_act);
    chk("R3", "cmd_pre", cmd_pre, m_pre);
    chk("R4", "cmd_rd", cmd_rd, m_rd);
    chk("R4", "cmd_wr", cmd_wr, m_wr);
    chk("R5", "strobe count", $countones({cmd_act, cmd_pre, cmd_rd, cmd_wr}) <= 1, 1);
    chk("R6", "bank_active", bank_active, m_active);
    chk("R2", "row_addr", row_addr, m_row);
    chk("R4", "col_addr", col_addr, m_col);
    chk("R4", "auto_pre", auto_pre, m_ap);
    chk("R4", "bank_o", bank_o, m_bank);
    chk("R10", "wr_mask", wr_mask, m_mask);
    chk("R7", "proto_err", proto_err, m_err);
    chk("R9", "suspend", suspend, m_susp);
    chk("R9", "pd_entry", pd_entry, m_pd);
  endtask

  // kind: 0 act, 1 pre, 2 rd, 3 wr, 4 other encoding
  task automatic apply(input logic rn, input logic ce, input logic sn, input int kind,
                       input logic [1:0] b, input logic [11:0] a, input logic [1:0] m);
    @(negedge clk);
    rst_n = rn; clk_en = ce; sel_n = sn; bank_sel = b; addr_in = a; byte_mask = m;
    case (kind)
      0: {ras, cas, we} = 3'b011;
      1: {ras, cas, we} = 3'b010;
      2: {ras, cas, we} = 3'b101;
      3: {ras, cas, we} = 3'b100;
      default: case ($urandom % 4)
        0: {ras, cas, we} = 3'b000;
        1: {ras, cas, we} = 3'b001;
        2: {ras, cas, we} = 3'b110;
        default: {ras, cas, we} = 3'b111;
      endcase
    endcase
    @(posedge clk);
    model_step();
    #5;
    compare();
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog all-R actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [3:0] snap;
    void'($urandom(32'd2024));
    model_reset();
    rst_n = 0; clk_en = 1; sel_n = 1; {ras, cas, we} = 3'b111;
    bank_sel = 0; addr_in = 0; byte_mask = 0;
    apply(0, 1, 0, 0, 2'd1, 12'hABC, 2'b11);
    apply(0, 1, 0, 3, 2'd1, 12'h5A5, 2'b01);
    chk("R11", "reset bank_active", bank_active, 0);
    chk("R11", "reset row_addr", row_addr, 0);

    // R2 activate bank 2, R4 write with auto-precharge, R10 mask
    apply(1, 1, 0, 0, 2'd2, 12'hF3C, 2'b00);
    chk("R2", "row latched", row_addr, 12'hF3C);
    apply(1, 1, 0, 3, 2'd2, 12'h5FF, 2'b10);
    chk("R4", "col latched", col_addr, 9'h1FF);
    chk("R10", "upper lane blocked", wr_mask, 2'b10);
    // R6 countdown: idle after BL edges
    for (int i = 1; i < BL; i++) apply(1, 1, 0, 4, 2'd0, 12'h0, 2'b00);
    chk("R6", "still active before burst end", bank_active[2], 1);
    apply(1, 1, 0, 4, 2'd0, 12'h0, 2'b00);
    chk("R6", "idle at burst end", bank_active[2], 0);

    // R7 read to idle bank
    apply(1, 1, 0, 2, 2'd3, 12'h123, 2'b00);
    chk("R7", "err on idle read", proto_err, 1);
    // R7 double activate
    apply(1, 1, 0, 0, 2'd1, 12'h111, 2'b00);
    apply(1, 1, 0, 0, 2'd1, 12'h222, 2'b00);
    chk("R7", "row kept on double act", row_addr, 12'h111);

    // R1 deselect
    snap = bank_active;
    apply(1, 1, 1, 1, 2'd1, 12'h333, 2'b00);
    chk("R1", "deselect keeps banks", bank_active, snap);

    // R8/R9 suspend with bank 1 active, auto-pre countdown frozen
    apply(1, 1, 0, 2, 2'd1, 12'h400, 2'b00);
    apply(1, 0, 0, 1, 2'd1, 12'h000, 2'b00);
    chk("R8", "precharge ignored when suspended", bank_active[1], 1);
    chk("R9", "suspend flag", suspend, 1);
    for (int i = 0; i < 6; i++) apply(1, 0, 0, 4, 2'd0, 12'h0, 2'b00);
    chk("R8", "countdown frozen", bank_active[1], 1);
    for (int i = 0; i < BL; i++) apply(1, 1, 1, 4, 2'd0, 12'h0, 2'b00);
    chk("R6", "idle after resumed countdown", bank_active[1], 0);
    apply(1, 0, 0, 0, 2'd0, 12'h0, 2'b00);
    chk("R9", "power-down entry when idle", pd_entry, 1);
    // R3 precharge of idle bank legal
    apply(1, 1, 0, 1, 2'd0, 12'h0, 2'b00);
    chk("R3", "pre strobe on idle bank", cmd_pre, 1);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      apply(($urandom % 500) != 0, ($urandom % 10) != 0, ($urandom % 8) == 0,
            int'($urandom % 5), 2'($urandom), 12'($urandom), 2'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule